// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns one asynchronous serial line into parallel characters. The line rests high. A character starts with a low start bit, carries 5 to 8 data bits least significant bit first, may carry a parity bit, and ends with at least one stop bit. A free-running enable, `sample_tick`, runs at sixteen times the bit rate. It times everything inside a bit. The receiver finds the falling start edge, counts sixteen ticks per bit, and decides each bit by a two-of-three vote over the samples in the middle of the bit period.

Each finished character is held in an output register together with its parity, framing, break and overrun flags. `rx_valid` marks the register as full. A one-cycle `rx_ready` pulse from the host takes the character and clears the flags. If the host leaves a character unread when the next one completes, the new character replaces it and the overrun flag is raised. If the line stays low through a whole character, stop bit included, this is reported as a break and not as a framing error. After either condition the receiver waits for the line to go high again before it looks for a new start bit.

Top module: `async_rx_os16`

## Requirements
- R1: After reset `rx_valid` is 0 and `rx_perr`, `rx_ferr`, `rx_brk` and `rx_ovr` are all 0. While `rx_valid` is 0 every flag stays 0.
- R2: A low level seen on a tick while idle starts a character. If the start bit's mid-bit vote reads high, the event is dropped as a false start: no character is produced and the receiver goes back to idle.
- R3: Every bit is decided by majority over the samples at tick counts 7, 8 and 9 of its 16-tick period, where count 0 is the tick that detected the start. A wrong level on only one of these samples does not change the received value.
- R4: `cfg_wlen` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first and appear right-aligned in `rx_data`, with all bits above the word length at 0.
- R5: When `cfg_par_en` is 1 a parity bit follows the data. With `cfg_par_odd` = 0 the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd` = 1, an odd number. A mismatch sets `rx_perr`. When `cfg_par_en` is 0 no parity bit is expected and `rx_perr` stays 0.
- R6: When the first stop bit votes low and the character is not a break, `rx_ferr` is set. Only the first stop bit is checked; further stop bits count as idle line.
- R7: When the start bit, every data bit, the parity bit (if enabled) and the first stop bit all vote low, the character is reported with `rx_brk` = 1, `rx_data` = 0, `rx_ferr` = 0 and `rx_perr` = 0.
- R8: After a framing error or a break, no new start is detected until the line has been seen high again.
- R9: A character stays on `rx_data` with `rx_valid` high and unchanged until a cycle with `rx_ready` = 1. In the cycle after that, `rx_valid` and all flags are 0, unless a new character completes in the same cycle.
- R10: When a character completes while `rx_valid` is 1 and `rx_ready` is 0, the new character replaces the old one, `rx_ovr` is set, and the error flags of both characters are ORed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_line | input | 1 | Serial input line, asynchronous to `clk`, idles high |
| cfg_wlen | input | 2 | Word length code: 0 for 5 bits up to 3 for 8 bits |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rx_ready | input | 1 | One-cycle pulse: the host takes the character and clears the flags |
| rx_valid | output | 1 | A character is waiting in the holding register |
| rx_data | output | 8 | Received character, right-aligned |
| rx_perr | output | 1 | Parity error (sticky until read) |
| rx_ferr | output | 1 | Framing error (sticky until read) |
| rx_brk | output | 1 | Break seen (sticky until read) |
| rx_ovr | output | 1 | Overrun: an unread character was replaced (sticky until read) |

## Verification
Line changes reach the voter two clocks later, through the synchronizer. A character and its flags reach the outputs one clock after the tick at count 9 of the first stop bit. The bench drives every bit for exactly sixteen ticks, changing the line on the falling clock edge after a tick, so the line settles before the next tick. It samples the outputs on a falling edge only after the whole stop bit has been sent, several ticks after that clock. A read takes effect on the rising edge after the `rx_ready` pulse, and the bench checks the cleared state on the next falling edge.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  localparam int unsigned CHAR_MAX = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_WAIT_HIGH
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_MAX-1:0] data;
    logic                perr;
    logic                ferr;
    logic                brk;
  } rx_char_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb pipe_d = din;
    end else begin : g_chain
      always_comb pipe_d = {pipe_q[STAGES-2:0], din};
    end
  endgenerate

  // line idles high, so reset to the idle level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/rx_bit_voter.sv
module rx_bit_voter
  import async_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxs,
  input  logic restart,
  input  logic active,
  output logic vote_stb,
  output logic vote_val,
  output logic bit_end
);

  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] C_SMP0 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] C_SMP1 = CW'(OSR/2);
  localparam logic [CW-1:0] C_SMP2 = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    smp_q, smp_d;
  logic          step;

  assign step = active & tick;

  always_comb begin
    cnt_d = cnt_q;
    smp_d = smp_q;
    if (restart) begin
      // the detecting tick itself is count 0
      cnt_d = CW'(1);
    end else if (step) begin
      cnt_d = (cnt_q == C_LAST) ? '0 : cnt_q + CW'(1);
      if (cnt_q == C_SMP0) smp_d[0] = rxs;
      if (cnt_q == C_SMP1) smp_d[1] = rxs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      smp_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      smp_q <= smp_d;
    end
  end

  assign vote_stb = step & (cnt_q == C_SMP2);
  assign vote_val = maj3(smp_q[0], smp_q[1], rxs);
  assign bit_end  = step & (cnt_q == C_LAST);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
#(
  parameter int unsigned MIN_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxs,
  input  logic       vote_stb,
  input  logic       vote_val,
  input  logic       bit_end,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       start_seen,
  output logic       active,
  output logic       done,
  output rx_char_t   chr
);

  localparam int unsigned IDX_W = $clog2(CHAR_MAX);

  rx_state_e           st_q, st_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [CHAR_MAX-1:0] sh_q, sh_d;
  logic                par_q, par_d;
  logic                zero_q, zero_d;
  logic [IDX_W-1:0]    last_idx;
  logic [IDX_W-1:0]    shamt;

  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_wlen);
  assign shamt    = IDX_W'(CHAR_MAX - 1) - last_idx;

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    par_d      = par_q;
    zero_d     = zero_q;
    start_seen = 1'b0;
    done       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tick && !rxs) begin
          start_seen = 1'b1;
          st_d       = ST_START;
          idx_d      = '0;
          sh_d       = '0;
          par_d      = 1'b0;
          zero_d     = 1'b1;
        end
      end
      ST_START: begin
        if (vote_stb && vote_val) st_d = ST_IDLE;
        else if (bit_end)         st_d = ST_DATA;
      end
      ST_DATA: begin
        if (vote_stb) begin
          sh_d   = {vote_val, sh_q[CHAR_MAX-1:1]};
          par_d  = par_q ^ vote_val;
          zero_d = zero_q & ~vote_val;
        end
        if (bit_end) begin
          if (idx_q == last_idx) st_d = cfg_par_en ? ST_PARITY : ST_STOP;
          else                   idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_PARITY: begin
        if (vote_stb) begin
          par_d  = par_q ^ vote_val;
          zero_d = zero_q & ~vote_val;
        end
        if (bit_end) st_d = ST_STOP;
      end
      ST_STOP: begin
        if (vote_stb) begin
          done = 1'b1;
          st_d = vote_val ? ST_IDLE : ST_WAIT_HIGH;
        end
      end
      ST_WAIT_HIGH: begin
        if (rxs) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      zero_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      zero_q <= zero_d;
    end
  end

  assign active = (st_q == ST_START) || (st_q == ST_DATA) ||
                  (st_q == ST_PARITY) || (st_q == ST_STOP);

  always_comb begin
    chr.brk  = zero_q & ~vote_val;
    chr.ferr = ~vote_val & ~zero_q;
    chr.perr = cfg_par_en & (par_q ^ cfg_par_odd) & ~chr.brk;
    chr.data = sh_q >> shamt;
  end

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
  import async_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  rx_char_t            chr,
  input  logic                rd,
  output logic                valid,
  output logic [CHAR_MAX-1:0] data,
  output logic                perr,
  output logic                ferr,
  output logic                brk,
  output logic                ovr
);

  logic                valid_q, valid_d;
  logic [CHAR_MAX-1:0] data_q, data_d;
  logic                perr_q, perr_d, ferr_q, ferr_d, brk_q, brk_d, ovr_q, ovr_d;
  logic                take, clobber;

  assign take    = valid_q & rd;
  assign clobber = valid_q & ~rd;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    brk_d   = brk_q;
    ovr_d   = ovr_q;
    if (load) begin
      valid_d = 1'b1;
      data_d  = chr.data;
      if (clobber) begin
        ovr_d  = 1'b1;
        perr_d = perr_q | chr.perr;
        ferr_d = ferr_q | chr.ferr;
        brk_d  = brk_q  | chr.brk;
      end else begin
        ovr_d  = 1'b0;
        perr_d = chr.perr;
        ferr_d = chr.ferr;
        brk_d  = chr.brk;
      end
    end else if (take) begin
      valid_d = 1'b0;
      perr_d  = 1'b0;
      ferr_d  = 1'b0;
      brk_d   = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      brk_q   <= brk_d;
      ovr_q   <= ovr_d;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign brk   = brk_q;
  assign ovr   = ovr_q;

endmodule

// File: rtl/async_rx_os16.sv
module async_rx_os16
  import async_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_BITS    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic                rx_line,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                rx_ready,
  output logic                rx_valid,
  output logic [CHAR_MAX-1:0] rx_data,
  output logic                rx_perr,
  output logic                rx_ferr,
  output logic                rx_brk,
  output logic                rx_ovr
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic     rxs;
  logic     start_seen, fsm_active, fsm_done;
  logic     vote_stb, vote_val, bit_end;
  rx_char_t fsm_chr;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (rx_line),
    .dout (rxs)
  );

  rx_bit_voter #(.OSR(OSR)) u_voter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (sample_tick),
    .rxs     (rxs),
    .restart (start_seen),
    .active  (fsm_active),
    .vote_stb(vote_stb),
    .vote_val(vote_val),
    .bit_end (bit_end)
  );

  rx_frame_fsm #(.MIN_BITS(MIN_BITS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (sample_tick),
    .rxs        (rxs),
    .vote_stb   (vote_stb),
    .vote_val   (vote_val),
    .bit_end    (bit_end),
    .cfg_wlen   (cfg_wlen),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .start_seen (start_seen),
    .active     (fsm_active),
    .done       (fsm_done),
    .chr        (fsm_chr)
  );

  rx_hold_reg u_hold (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (fsm_done),
    .chr  (fsm_chr),
    .rd   (rx_ready),
    .valid(rx_valid),
    .data (rx_data),
    .perr (rx_perr),
    .ferr (rx_ferr),
    .brk  (rx_brk),
    .ovr  (rx_ovr)
  );

endmodule

// File: rtl/async_rx_os16_chk.sv
module async_rx_os16_chk
  import async_rx_pkg::*;
#(
  parameter int unsigned MIN_BITS = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cfg_wlen,
  input logic                rx_ready,
  input logic                rx_valid,
  input logic [CHAR_MAX-1:0] rx_data,
  input logic                rx_perr,
  input logic                rx_ferr,
  input logic                rx_brk,
  input logic                rx_ovr,
  input logic                done,
  input rx_char_t            chr
);

  assert_idle_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(rx_perr || rx_ferr || rx_brk || rx_ovr));

  assert_char_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((chr.data >> (MIN_BITS + int'(cfg_wlen))) == '0));

  assert_break_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk && !rx_ovr) |-> (rx_data == '0 && !rx_ferr && !rx_perr));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done) |=> (rx_valid && $stable(rx_data)));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !done) |=>
      (!rx_valid && !rx_ovr && !rx_perr && !rx_ferr && !rx_brk));

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && done) |=> (rx_valid && rx_ovr));

endmodule

bind async_rx_os16 async_rx_os16_chk #(.MIN_BITS(MIN_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_wlen(cfg_wlen),
  .rx_ready(rx_ready),
  .rx_valid(rx_valid),
  .rx_data (rx_data),
  .rx_perr (rx_perr),
  .rx_ferr (rx_ferr),
  .rx_brk  (rx_brk),
  .rx_ovr  (rx_ovr),
  .done    (fsm_done),
  .chr     (fsm_chr)
);

// File: tb/async_rx_os16_test.sv
module async_rx_os16_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic       pen = 1'b0;
  logic       podd = 1'b0;
  logic       rdy = 1'b0;
  logic       v;
  logic [7:0] dout;
  logic       perr, ferr, brk, ovr;

  int n_tests = 0;
  int n_fail  = 0;
  int tdiv    = 0;

  always #10 clk = ~clk;

  async_rx_os16 uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .rx_line(rxd),
    .cfg_wlen(wlen), .cfg_par_en(pen), .cfg_par_odd(podd), .rx_ready(rdy),
    .rx_valid(v), .rx_data(dout), .rx_perr(perr), .rx_ferr(ferr),
    .rx_brk(brk), .rx_ovr(ovr)
  );

  // 16x enable: one clock in four
  initial begin
    forever begin
      @(negedge clk);
      tdiv = tdiv + 1;
      tick = (tdiv % 4 == 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL R9 watchdog: actual run not finished, expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests = n_tests + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic drive_bit(input logic b, input bit glitch);
    @(negedge clk) rxd = b;
    if (glitch) begin
      wait_ticks(8);
      @(negedge clk) rxd = ~b;
      wait_ticks(1);
      @(negedge clk) rxd = b;
      wait_ticks(7);
    end else begin
      wait_ticks(16);
    end
  endtask

  // gl: 0 glitches start, 1..n a data bit, n+1 parity, -1 none
  task automatic send_frame(input logic [7:0] d, input int n, input bit pe,
                            input logic pb, input logic stopv, input int gl);
    wait_ticks(1);
    drive_bit(1'b0, gl == 0);
    for (int i = 0; i < n; i++) drive_bit(d[i], gl == i + 1);
    if (pe) drive_bit(pb, gl == n + 1);
    drive_bit(stopv, 1'b0);
    @(negedge clk) rxd = 1'b1;
  endtask

  function automatic logic [7:0] mask_of(input int n);
    return 8'((16'h1 << n) - 1);
  endfunction

  function automatic logic [3:0] exp_flags(input logic [7:0] d, input int n, input bit pe,
                                           input bit odd, input logic pb, input logic stopv);
    logic [7:0] dm;
    logic b, f, p;
    dm = d & mask_of(n);
    b  = (dm == 0) && (!pe || pb == 1'b0) && (stopv == 1'b0);
    f  = !stopv && !b;
    p  = pe && !b && ((^dm ^ pb) != odd);
    return {1'b0, p, f, b};
  endfunction

  task automatic read_char(input string tag);
    @(negedge clk) rdy = 1'b1;
    @(negedge clk) rdy = 1'b0;
    chk({tag, " read clears valid"}, int'(v), 0);
    chk({tag, " read clears flags"}, int'({perr, ferr, brk, ovr}), 0);
  endtask

  task automatic expect_char(input string tag, input logic [7:0] d, input logic [3:0] fl,
                             input logic o);
    @(negedge clk);
    chk({tag, " valid"}, int'(v), 1);
    chk({tag, " data"}, int'(dout), int'(d));
    chk({tag, " perr/ferr/brk"}, int'({perr, ferr, brk}), int'(fl[2:0]));
    chk({tag, " ovr"}, int'(ovr), int'(o));
  endtask

  initial begin
    logic [7:0] d;
    logic [3:0] fl;
    int n;
    logic pb;
    logic sv;
    int gl;
    int seed;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset valid", int'(v), 0);
    chk("R1 reset flags", int'({perr, ferr, brk, ovr}), 0);

    // R2 false start: low for 4 ticks only
    wait_ticks(1);
    @(negedge clk) rxd = 1'b0;
    wait_ticks(4);
    @(negedge clk) rxd = 1'b1;
    wait_ticks(40);
    @(negedge clk);
    chk("R2 false start gives no char", int'(v), 0);
    send_frame(8'hA5, 8, 0, 0, 1, -1);
    expect_char("R2 frame after false start", 8'hA5, 4'h0, 0);
    read_char("R9");

    // R3 single-sample glitches
    send_frame(8'h5A, 8, 0, 0, 1, 4);
    expect_char("R3 glitch data bit", 8'h5A, 4'h0, 0);
    read_char("R9");
    send_frame(8'h81, 8, 0, 0, 1, 0);
    expect_char("R3 glitch start bit", 8'h81, 4'h0, 0);
    read_char("R9");

    // R4 word lengths, upper stimulus bits must not appear
    wlen = 2'd0;
    send_frame(8'hF5, 5, 0, 0, 1, -1);
    expect_char("R4 5-bit", 8'h15, 4'h0, 0);
    read_char("R9");
    wlen = 2'd2;
    send_frame(8'hC3, 7, 0, 0, 1, -1);
    expect_char("R4 7-bit", 8'h43, 4'h0, 0);
    read_char("R9");

    // R5 parity
    wlen = 2'd3; pen = 1'b1; podd = 1'b0;
    send_frame(8'h07, 8, 1, 1, 1, -1);
    expect_char("R5 even good", 8'h07, 4'h0, 0);
    read_char("R9");
    send_frame(8'h07, 8, 1, 0, 1, -1);
    expect_char("R5 even bad", 8'h07, 4'h4, 0);
    read_char("R9");
    podd = 1'b1;
    send_frame(8'h03, 8, 1, 0, 1, -1);
    expect_char("R5 odd bad", 8'h03, 4'h4, 0);
    read_char("R9");
    pen = 1'b0; podd = 1'b0;

    // R6 framing error, then R8 re-arm after line high
    send_frame(8'h3C, 8, 0, 0, 0, -1);
    expect_char("R6 framing", 8'h3C, 4'h2, 0);
    read_char("R9");
    send_frame(8'h66, 8, 0, 0, 1, -1);
    expect_char("R8 frame after framing error", 8'h66, 4'h0, 0);
    read_char("R9");

    // R7 break, R8 no re-arm while low
    wait_ticks(1);
    @(negedge clk) rxd = 1'b0;
    wait_ticks(16 * 12);
    expect_char("R7 break", 8'h00, 4'h1, 0);
    read_char("R7");
    wait_ticks(60);
    @(negedge clk);
    chk("R8 no char while line stays low", int'(v), 0);
    @(negedge clk) rxd = 1'b1;
    wait_ticks(5);
    send_frame(8'h99, 8, 0, 0, 1, -1);
    expect_char("R8 frame after break", 8'h99, 4'h0, 0);

    // R9 hold stable while unread
    wait_ticks(50);
    expect_char("R9 held unread", 8'h99, 4'h0, 0);

    // R10 overrun with error OR-ing
    pen = 1'b1;
    send_frame(8'h01, 8, 1, 0, 1, -1);
    expect_char("R10 overrun", 8'h01, 4'h4, 1);
    read_char("R10");
    pen = 1'b0;

    // constrained random frames
    seed = $urandom(32'h5eed_1234);
    for (int k = 0; k < 60; k++) begin
      wlen = 2'($urandom_range(0, 3));
      pen  = 1'($urandom_range(0, 1));
      podd = 1'($urandom_range(0, 1));
      n    = 5 + int'(wlen);
      d    = 8'($urandom);
      if ($urandom_range(0, 5) == 0) d = 8'h00;
      pb   = (^(d & mask_of(n))) ^ podd;
      if ($urandom_range(0, 3) == 0) pb = ~pb;
      sv   = ($urandom_range(0, 5) != 0);
      gl   = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, n + (pen ? 1 : 0)));
      fl   = exp_flags(d, n, pen, podd, pb, sv);
      send_frame(d, n, pen, pb, sv, gl);
      expect_char("R4 R5 R6 R7 random", d & mask_of(n), fl, 0);
      read_char("R9");
      wait_ticks($urandom_range(1, 20));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule